// File: doc/BRIEF.md
# Programmable Parallel Output Delay Path

This block is the transmit datapath of a source-synchronous parallel interface. It runs on the fast clock and derives the core-clock boundary from a free-running two-bit phase counter, so one core cycle spans four fast cycles. On each core boundary it samples a word of eight bits per pin, a data output enable and a strobe output enable. These pass through a pipeline of fixed stages plus a configurable number of extra stages. The data is then written into an eight-entry transmit FIFO.

The FIFO read enable is a copy of the write pulse sent through a sixteen-tap shift register. The integer field of an 11-bit delay register selects the tap, so data leaves the FIFO 0 to 15 fast cycles later than it otherwise would. Each word read is sent out as quarter-rate DDR, two bits per pin per fast cycle over four fast cycles. The strobe follows the same path and toggles during every core cycle in which its enable was sampled high, so raising the strobe enable one core cycle early gives a preamble. The fractional field of the delay register is not applied inside the block. It is exported as a 7-bit phase code for an external fine phase shifter, together with a strobe code that can be offset by a quarter period so that strobe edges land at the centre of the data eyes.

Top module: `pdly_tx_path`

## Requirements
- R1: After reset, dq_out and dqs_out are 0, dq_tri and dqs_tri are 1, both error flags are 0, dq_phase is 0 and dqs_phase is 32 (with STRB_CENTER=1).
- R2: The first fast-clock edge after reset is a core boundary, and every fourth edge after it is one too. A word sampled with dq_oe high at boundary edge n first appears after edge n + 4*(BASE_LAT+ADD_LAT) + 1 + D, where D is the integer delay in force. Pin p takes din[8p+7:8p]. In the j-th cycle (j = 0..3) it shows bits [8p+2j+1:8p+2j] on dq_out[2p+1:2p].
- R3: The integer delay D is bits [10:7] of the delay register, with a range of 0 to 15 fast cycles. Both ends of the range give the timing of R2.
- R4: dq_phase carries bits [6:0] of the delay register in force. dqs_phase is that code plus 32, modulo 128.
- R5: A delay register value written at edge n takes effect at the first core boundary after n. Both phase outputs change after edge n+4, not earlier.
- R6: For each core cycle sampled with dqs_oe high, dqs_out shows 2'b10 and dqs_tri is 0 for four fast cycles, with the same timing as data. Raising dqs_oe one core cycle before dq_oe makes the strobe start four fast cycles before the first data pair.
- R7: In any cycle that carries no data, dq_out is 0 and dq_tri is 1. In any cycle that carries no strobe, dqs_out is 0 and dqs_tri is 1.
- R8: A FIFO read while the FIFO is empty sets fifo_udf. The flag stays set until it is cleared.
- R9: A FIFO write while the FIFO holds 8 entries, with no read in the same cycle, sets fifo_ovf. The flag stays set until it is cleared.
- R10: A cycle with err_clr high clears both error flags.
- R11: Words sampled in consecutive core cycles leave with no gap between them, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | NPIN*8 | Word from the core, eight bits per pin |
| dq_oe | input | 1 | Data output enable, sampled at core boundaries |
| dqs_oe | input | 1 | Strobe output enable, sampled at core boundaries |
| cfg_we | input | 1 | Write strobe for the delay register |
| cfg_wdata | input | 11 | Delay value: [10:7] integer cycles, [6:0] fine steps |
| err_clr | input | 1 | Clears both sticky FIFO flags |
| dq_out | output | NPIN*2 | Two serialized bits per pin per fast cycle |
| dq_tri | output | 1 | High when the data pins are released |
| dqs_out | output | 2 | Strobe bit pair per fast cycle |
| dqs_tri | output | 1 | High when the strobe is released |
| dq_phase | output | 7 | Fine phase code for the data path |
| dqs_phase | output | 7 | Fine phase code for the strobe |
| fifo_ovf | output | 1 | Sticky FIFO overflow flag |
| fifo_udf | output | 1 | Sticky FIFO underflow flag |

## Verification
The assertions assume that the delay field changes only while no pulse is travelling through the tap line. If it changed mid-flight, a pulse could be skipped or read twice, and the timing relation of R2 would no longer hold. The stimulus therefore changes the delay only after the path has drained, except in two deliberate scenarios. In those it moves the tap across a pulse in flight to strand FIFO entries or to cause a second read, which drives the overflow and underflow flags through the block's normal inputs. During those two scenarios, and only then, the pin-level reference comparison is switched off.

// File: rtl/pdly_pkg.sv
package pdly_pkg;
    localparam int RATIO  = 4;                 // fast cycles per core cycle
    localparam int PH_W   = $clog2(RATIO);
    localparam int INT_W  = 4;
    localparam int FINE_W = 7;
    localparam int CFG_W  = INT_W + FINE_W;
    localparam int QTR    = (1 << FINE_W) / 4; // a quarter period in fine steps

    typedef struct packed {
        logic [INT_W-1:0]  intd;   // bits [10:7]
        logic [FINE_W-1:0] fine;   // bits [6:0]
    } dly_cfg_t;
endpackage

// File: rtl/pdly_pipe.sv
module pdly_pipe #(
    parameter int NPIN = 2,
    parameter int NST  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [NPIN*8-1:0] din,
    input  logic              dq_oe,
    input  logic              dqs_oe,
    output logic [NPIN*8-1:0] word,
    output logic              wr_pulse,
    output logic              str_pulse
);
    localparam int WW = NPIN * 8;

    typedef struct packed {
        logic          doe;
        logic          soe;
        logic [WW-1:0] dat;
    } stage_t;

    typedef struct packed {
        stage_t [NST-1:0] st;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.st[0].doe = dq_oe;
            s_d.st[0].soe = dqs_oe;
            s_d.st[0].dat = din;
            for (int i = 1; i < NST; i++) begin
                s_d.st[i] = s_q.st[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign word      = s_q.st[NST-1].dat;
    assign wr_pulse  = tick & s_q.st[NST-1].doe;
    assign str_pulse = tick & s_q.st[NST-1].soe;
endmodule

// File: rtl/pdly_tap.sv
module pdly_tap #(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          d_in,
    input  logic          s_in,
    input  logic [IW-1:0] tap,
    output logic          d_out,
    output logic          s_out
);
    localparam int LEN = 1 << IW;

    typedef struct packed {
        logic [LEN-1:0] dsr;
        logic [LEN-1:0] ssr;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.dsr = {s_q.dsr[LEN-2:0], d_in};
        s_d.ssr = {s_q.ssr[LEN-2:0], s_in};
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // tap 0 is already one register past the input
    assign d_out = s_q.dsr[tap];
    assign s_out = s_q.ssr[tap];
endmodule

// File: rtl/pdly_fifo.sv
module pdly_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8     // power of two
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    input  logic         clr,
    output logic         ovf,
    output logic         udf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
        logic                    ovf;
        logic                    udf;
    } state_t;

    state_t s_d, s_q;
    logic full, empty, do_wr, do_rd;

    always_comb begin
        full  = (s_q.cnt == CW'(DEPTH));
        empty = (s_q.cnt == '0);
        do_wr = wr & (~full | rd);
        do_rd = rd & ~empty;
        s_d   = s_q;
        if (do_wr) begin
            s_d.mem[s_q.wp] = wdata;
            s_d.wp          = s_q.wp + 1'b1;
        end
        if (do_rd) s_d.rp = s_q.rp + 1'b1;
        s_d.cnt = s_q.cnt + CW'(do_wr) - CW'(do_rd);
        if (clr) begin
            s_d.ovf = 1'b0;
            s_d.udf = 1'b0;
        end
        if (wr & full & ~rd) s_d.ovf = 1'b1;
        if (rd & empty)      s_d.udf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign rdata = empty ? '0 : s_q.mem[s_q.rp];
    assign ovf   = s_q.ovf;
    assign udf   = s_q.udf;

    // R9
    ovf_on_full_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && s_q.cnt == CW'(DEPTH) && !rd) |=> ovf);
    // R8
    udf_on_empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && s_q.cnt == '0) |=> udf);
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);
    // R10
    udf_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !(rd && s_q.cnt == '0)) |=> !udf);
endmodule

// File: rtl/pdly_ser.sv
module pdly_ser #(
    parameter int NPIN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [NPIN*8-1:0] word,
    input  logic              sld,
    output logic [NPIN*2-1:0] dq_out,
    output logic              dq_tri,
    output logic [1:0]        dqs_out,
    output logic              dqs_tri
);
    import pdly_pkg::*;

    localparam int WW = NPIN * 8;
    localparam int OW = NPIN * 2;

    typedef struct packed {
        logic [WW-1:0]   sh;
        logic [PH_W-1:0] rem;
        logic [OW-1:0]   dout;
        logic            act;
        logic [PH_W-1:0] srem;
        logic [1:0]      sout;
        logic            sact;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ld) begin
            for (int p = 0; p < NPIN; p++) begin
                s_d.dout[p*2 +: 2] = word[p*8 +: 2];
                s_d.sh[p*8 +: 8]   = {2'b00, word[p*8+2 +: 6]};
            end
            s_d.rem = PH_W'(RATIO - 1);
            s_d.act = 1'b1;
        end else if (s_q.rem != '0) begin
            for (int p = 0; p < NPIN; p++) begin
                s_d.dout[p*2 +: 2] = s_q.sh[p*8 +: 2];
                s_d.sh[p*8 +: 8]   = {2'b00, s_q.sh[p*8+2 +: 6]};
            end
            s_d.rem = s_q.rem - 1'b1;
            s_d.act = 1'b1;
        end else begin
            s_d.dout = '0;
            s_d.act  = 1'b0;
        end

        if (sld) begin
            s_d.sout = 2'b10;
            s_d.srem = PH_W'(RATIO - 1);
            s_d.sact = 1'b1;
        end else if (s_q.srem != '0) begin
            s_d.sout = 2'b10;
            s_d.srem = s_q.srem - 1'b1;
            s_d.sact = 1'b1;
        end else begin
            s_d.sout = 2'b00;
            s_d.sact = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign dq_out  = s_q.dout;
    assign dq_tri  = ~s_q.act;
    assign dqs_out = s_q.sout;
    assign dqs_tri = ~s_q.sact;

    // R7
    data_idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld && s_q.rem == '0) |=> (dq_tri && dq_out == '0));
    // R6
    strobe_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        sld |=> (dqs_out == 2'b10 && !dqs_tri));
endmodule

// File: rtl/pdly_tx_path.sv
module pdly_tx_path #(
    parameter int NPIN        = 2,
    parameter int BASE_LAT    = 2,
    parameter int ADD_LAT     = 1,
    parameter int FIFO_DEPTH  = 8,
    parameter bit STRB_CENTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPIN*8-1:0] din,
    input  logic              dq_oe,
    input  logic              dqs_oe,
    input  logic              cfg_we,
    input  logic [10:0]       cfg_wdata,
    input  logic              err_clr,
    output logic [NPIN*2-1:0] dq_out,
    output logic              dq_tri,
    output logic [1:0]        dqs_out,
    output logic              dqs_tri,
    output logic [6:0]        dq_phase,
    output logic [6:0]        dqs_phase,
    output logic              fifo_ovf,
    output logic              fifo_udf
);
    import pdly_pkg::*;

    localparam int NST = BASE_LAT + ADD_LAT;
    localparam int WW  = NPIN * 8;
    localparam logic [FINE_W-1:0] SOFS = STRB_CENTER ? FINE_W'(QTR) : '0;

    typedef struct packed {
        logic [PH_W-1:0] ph;
        dly_cfg_t        cfg;   // as written
        dly_cfg_t        app;   // in force, updated at core boundaries
    } state_t;

    state_t s_d, s_q;
    logic tick;

    always_comb begin
        tick = (s_q.ph == '0);
        s_d    = s_q;
        s_d.ph = s_q.ph + 1'b1;
        if (cfg_we) s_d.cfg = dly_cfg_t'(cfg_wdata);
        if (tick)   s_d.app = s_q.cfg;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    logic [WW-1:0] st_word, fifo_word;
    logic          wr_pulse, str_pulse, rd_en, str_en;

    pdly_pipe #(.NPIN(NPIN), .NST(NST)) u_pipe (
        .clk(clk), .rst(rst), .tick(tick),
        .din(din), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
        .word(st_word), .wr_pulse(wr_pulse), .str_pulse(str_pulse)
    );

    pdly_tap #(.IW(INT_W)) u_tap (
        .clk(clk), .rst(rst),
        .d_in(wr_pulse), .s_in(str_pulse), .tap(s_q.app.intd),
        .d_out(rd_en), .s_out(str_en)
    );

    pdly_fifo #(.W(WW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .wr(wr_pulse), .wdata(st_word),
        .rd(rd_en), .rdata(fifo_word),
        .clr(err_clr), .ovf(fifo_ovf), .udf(fifo_udf)
    );

    pdly_ser #(.NPIN(NPIN)) u_ser (
        .clk(clk), .rst(rst),
        .ld(rd_en), .word(fifo_word), .sld(str_en),
        .dq_out(dq_out), .dq_tri(dq_tri),
        .dqs_out(dqs_out), .dqs_tri(dqs_tri)
    );

    assign dq_phase  = s_q.app.fine;
    assign dqs_phase = s_q.app.fine + SOFS;

    // R5
    cfg_boundary_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(s_q.app));
endmodule

// File: tb/pdly_tx_path_tb.sv
module pdly_tx_path_tb;
    localparam int NPIN = 2;
    localparam int BASE_LAT = 2;
    localparam int ADD_LAT = 1;
    localparam int NST = BASE_LAT + ADD_LAT;
    localparam int WW = NPIN * 8;
    localparam int OW = NPIN * 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [WW-1:0] din = '0;
    logic dq_oe = 1'b0, dqs_oe = 1'b0, cfg_we = 1'b0, err_clr = 1'b0;
    logic [10:0] cfg_wdata = '0;
    logic [OW-1:0] dq_out;
    logic dq_tri, dqs_tri, fifo_ovf, fifo_udf;
    logic [1:0] dqs_out;
    logic [6:0] dq_phase, dqs_phase;

    pdly_tx_path #(.NPIN(NPIN), .BASE_LAT(BASE_LAT), .ADD_LAT(ADD_LAT)) u_dut (
        .clk(clk), .rst(rst), .din(din), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .err_clr(err_clr),
        .dq_out(dq_out), .dq_tri(dq_tri), .dqs_out(dqs_out), .dqs_tri(dqs_tri),
        .dq_phase(dq_phase), .dqs_phase(dqs_phase),
        .fifo_ovf(fifo_ovf), .fifo_udf(fifo_udf)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit model_on = 1'b0;

    typedef struct {
        int            at;
        logic [WW-1:0] w;
        bit            d;
        bit            s;
    } arr_t;

    arr_t pend[$];
    logic [OW-1:0] exp_d[int];
    bit exp_s[int];
    logic [10:0] m_cfg = '0;
    logic [10:0] m_app = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, expv, cyc - 1);
        end
    endtask

    // Reference model: event times counted in fast edges since reset release
    always @(posedge clk) begin
        if (rst) begin
            cyc = 0;
        end else begin
            int e;
            e = cyc;
            cyc = cyc + 1;
            if (e % 4 == 0) begin
                m_app = m_cfg;
                if (dq_oe || dqs_oe) pend.push_back('{e + 4 * NST, din, dq_oe, dqs_oe});
                while (pend.size() > 0 && pend[0].at == e) begin
                    arr_t a;
                    int st;
                    a = pend.pop_front();
                    st = e + 1 + int'(m_app[10:7]);
                    for (int j = 0; j < 4; j++) begin
                        logic [OW-1:0] v;
                        for (int p = 0; p < NPIN; p++) v[p*2 +: 2] = a.w[p*8 + 2*j +: 2];
                        if (a.d) exp_d[st + j] = v;
                        if (a.s) exp_s[st + j] = 1'b1;
                    end
                end
            end
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    always @(negedge clk) begin
        if (!rst && model_on && cyc > 0) begin
            int m;
            m = cyc - 1;
            chk("R2 R3 R11 pin data", dq_out, exp_d.exists(m) ? exp_d[m] : '0);
            chk("R7 data release", dq_tri, exp_d.exists(m) ? 1'b0 : 1'b1);
            chk("R6 strobe pattern", dqs_out, exp_s.exists(m) ? 2'b10 : 2'b00);
            chk("R7 strobe release", dqs_tri, exp_s.exists(m) ? 1'b0 : 1'b1);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        dq_oe = 0; dqs_oe = 0; cfg_we = 0; err_clr = 0; din = '0; cfg_wdata = '0;
        pend.delete();
        exp_d.delete();
        exp_s.delete();
        m_cfg = '0;
        m_app = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // one core cycle: inputs change just before a boundary edge
    task automatic step(input logic d_oe, input logic s_oe, input logic [WW-1:0] w,
                        input logic we, input logic [10:0] cv, input logic clr);
        do @(negedge clk); while (cyc % 4 != 0);
        dq_oe = d_oe; dqs_oe = s_oe; din = w;
        cfg_we = we; cfg_wdata = cv; err_clr = clr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic set_delay(input int intd, input int fine);
        step(1'b0, 1'b0, '0, 1'b1, {4'(intd), 7'(fine)}, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R2 watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 dq_out", dq_out, 0);
        chk("R1 dq_tri", dq_tri, 1);
        chk("R1 dqs_tri", dqs_tri, 1);
        chk("R1 fifo_ovf", fifo_ovf, 0);
        chk("R1 fifo_udf", fifo_udf, 0);
        chk("R1 dq_phase", dq_phase, 0);
        chk("R1 dqs_phase", dqs_phase, 32);

        model_on = 1'b1;
        // R2 R3: single word with zero integer delay
        step(1'b1, 1'b0, 16'hA5C3, 1'b0, '0, 1'b0);
        idle(NST + 3);

        // R3 R11 R6: delay 5, preamble then three consecutive words
        set_delay(5, 0);
        idle(1);
        step(1'b0, 1'b1, '0, 1'b0, '0, 1'b0);
        step(1'b1, 1'b1, 16'h1234, 1'b0, '0, 1'b0);
        step(1'b1, 1'b1, 16'hFEDC, 1'b0, '0, 1'b0);
        step(1'b1, 1'b1, 16'h0F96, 1'b0, '0, 1'b0);
        idle(NST + 6);

        // R3 upper end, R6 preamble
        set_delay(15, 0);
        idle(1);
        step(1'b0, 1'b1, '0, 1'b0, '0, 1'b0);
        step(1'b1, 1'b1, 16'h5A3C, 1'b0, '0, 1'b0);
        step(1'b1, 1'b1, 16'hC0DE, 1'b0, '0, 1'b0);
        idle(NST + 8);

        // R4 R5: phase code changes only at the next boundary
        idle(1);
        set_delay(15, 100);
        @(negedge clk);
        chk("R5 phase held after write edge", dq_phase, 0);
        repeat (2) @(negedge clk);
        chk("R5 phase held before boundary", dq_phase, 0);
        @(negedge clk);
        chk("R5 phase held at edge n+3", dq_phase, 0);
        @(negedge clk);
        chk("R4 R5 dq_phase applied", dq_phase, 100);
        chk("R4 dqs_phase wraps", dqs_phase, 4);
        idle(2);

        // R8 R10: tap moved across an in-flight pulse reads it twice
        model_on = 1'b0;
        set_delay(0, 0);
        idle(2);
        step(1'b1, 1'b0, 16'h7777, 1'b0, '0, 1'b0);
        idle(NST - 1);
        set_delay(15, 0);
        idle(3);
        chk("R8 no underflow before second read", fifo_udf, 0);
        idle(2);
        chk("R8 underflow set", fifo_udf, 1);
        chk("R9 no overflow during underflow", fifo_ovf, 0);
        idle(3);
        chk("R8 underflow sticky", fifo_udf, 1);
        step(1'b0, 1'b0, '0, 1'b0, '0, 1'b1);
        idle(1);
        chk("R10 underflow cleared", fifo_udf, 0);

        // R9 R10: strand entries by moving the tap past in-flight pulses
        do_reset();
        set_delay(15, 0);
        idle(1);
        for (int r = 0; r < 9; r++) begin
            step(1'b1, 1'b0, 16'(r), 1'b0, '0, 1'b0);
            idle(NST - 1);
            set_delay(0, 0);
            idle(3);
            set_delay(15, 0);
            idle(1);
            if (r == 7) begin
                chk("R9 no overflow at eight entries", fifo_ovf, 0);
                chk("R8 no underflow while stranding", fifo_udf, 0);
            end
        end
        chk("R9 overflow on ninth write", fifo_ovf, 1);
        idle(2);
        chk("R9 overflow sticky", fifo_ovf, 1);
        step(1'b0, 1'b0, '0, 1'b0, '0, 1'b1);
        idle(1);
        chk("R10 overflow cleared", fifo_ovf, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule